// File: doc/BRIEF.md
# Debug Bus Access Unit

This unit performs debug memory reads and writes on the target's 16-bit system bus on behalf of the debug shift logic. A request carries an address, a size (byte or word), a direction and a 16-bit write word. The unit holds the request, waits for a cycle in which the CPU leaves the bus idle, and then steals that cycle for the access. Read results land in a 16-bit read register.

The wait for a free cycle has a firm upper bound. If the CPU keeps the bus busy for the full limit, the unit takes the next cycle anyway. Word accesses are always made at an even address: address bit 0 is dropped without any error indication. The bus is big-endian by lane. Byte accesses to an even address use the upper lane and byte accesses to an odd address use the lower lane. A byte read still returns a full 16-bit word, with the lane that was not read cleared to zero.

Top module: `dbg_access_top`

## Requirements
- R1: After reset `pending`, `done` and `busValid` are 0 and `readData` is 0.
- R2: A request (`reqValid` high while not pending) is latched at the clock edge, and `pending` is 1 in the next cycle. Requests that arrive while `pending` is 1 are ignored: they do not change the address, direction or data of the access in flight, and they do not cause an extra access.
- R3: While pending, `busValid` is 1 in the first cycle in which `cpuBusy` is 0, and it is 0 in every earlier cycle in which `cpuBusy` is 1 and the bound of R4 has not been reached.
- R4: If `cpuBusy` stays at 1, the access is forced once STEAL_LIMIT (128) pending cycles have passed. It happens in pending cycle index 128, counted from 0, whatever the state of `cpuBusy`.
- R5: `busAddr` is always the request address with bit 0 cleared, for every size and direction.
- R6: A word read loads `readData` with the full bus word.
- R7: A byte read from an even address loads `readData[15:8]` with bus bits [15:8] and sets `readData[7:0]` to zero.
- R8: A byte read from an odd address loads `readData[7:0]` with bus bits [7:0] and sets `readData[15:8]` to zero.
- R9: `busWdata` equals the request's write word. `busBe` is 2'b11 for a word access, 2'b10 (upper lane) for an even byte address and 2'b01 (lower lane) for an odd byte address.
- R10: `done` is 1 for exactly one cycle, in the cycle after the access cycle. `pending` is 0 in that same cycle.
- R11: A write access leaves `readData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request strobe from the debug shift logic |
| reqAddr | input | 16 | Byte address of the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqByte | input | 1 | 1 = byte access, 0 = word access |
| reqWdata | input | 16 | Write word (a byte write uses the half that matches its lane) |
| cpuBusy | input | 1 | CPU owns the bus in this cycle |
| busValid | output | 1 | Stolen bus cycle in progress |
| busWrite | output | 1 | Direction of the stolen cycle |
| busAddr | output | 16 | Even word address on the bus |
| busBe | output | 2 | Lane enables, bit 1 = upper lane (even byte) |
| busWdata | output | 16 | Write data on the bus |
| busRdata | input | 16 | Read data returned in the same cycle as busValid |
| readData | output | 16 | Read result register |
| pending | output | 1 | An access is waiting for a bus cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `busRdata` is valid in the same cycle as `busValid`, and that `cpuBusy` is a clean level with no unknown values. The bench meets both conditions with a combinational memory model and a `cpuBusy` that is driven only at falling edges. The assertions also assume that the debug side keeps each request steady for the single cycle in which it is accepted. They do not assume that it refrains from asserting `reqValid` while an access is pending. The stimulus deliberately asserts it there, to show that such requests have no effect.

// File: rtl/dap_pkg.sv
`timescale 1ns/1ps
package dap_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic accept;   // latch a new request
    logic issue;    // steal this bus cycle
  } dapStrobes_t;
endpackage

// File: rtl/dap_ctrl.sv
`timescale 1ns/1ps
module dap_ctrl
  import dap_pkg::*;
#(
  parameter int STEAL_LIMIT = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        cpuBusy,
  output dapStrobes_t strobes,
  output logic        pending,
  output logic        done
);
  localparam int CNT_W = $clog2(STEAL_LIMIT + 1);

  typedef enum logic {ST_IDLE, ST_WAIT} ctrlState_t;

  ctrlState_t       state;
  logic [CNT_W-1:0] waitCnt;
  logic             limitHit;

  assign limitHit = (waitCnt == CNT_W'(STEAL_LIMIT));
  assign pending  = (state == ST_WAIT);

  always_comb begin
    strobes.accept = (state == ST_IDLE) && reqValid;
    strobes.issue  = (state == ST_WAIT) && (!cpuBusy || limitHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobes.issue;
      unique case (state)
        ST_IDLE: begin
          waitCnt <= '0;
          if (strobes.accept) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (strobes.issue) begin
            state   <= ST_IDLE;
            waitCnt <= '0;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> (waitCnt <= CNT_W'(STEAL_LIMIT))); // R4

  AST_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (pending && cpuBusy && (waitCnt < CNT_W'(STEAL_LIMIT))) |=> pending); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
endmodule

// File: rtl/dap_datapath.sv
`timescale 1ns/1ps
module dap_datapath
  import dap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dapStrobes_t       strobes,
  input  logic              pending,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqByte,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busBe,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] readData
);
  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic              byteQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] steered;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= 1'b0;
      byteQ  <= 1'b0;
      wdataQ <= '0;
    end else if (strobes.accept) begin
      addrQ  <= reqAddr;
      writeQ <= reqWrite;
      byteQ  <= reqByte;
      wdataQ <= reqWdata;
    end
  end

  // Word bus: bit 0 never reaches the bus
  assign busAddr  = {addrQ[ADDR_W-1:1], 1'b0};
  assign busWrite = writeQ;
  assign busWdata = wdataQ;

  // Lane enables and read steering; lane 1 = upper half = even byte
  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic laneSel;
    assign laneSel = !byteQ || (addrQ[0] == (lane == 0));
    assign busBe[lane] = laneSel;
    assign steered[lane*HALF_W +: HALF_W] =
      laneSel ? busRdata[lane*HALF_W +: HALF_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readData <= '0;
    end else if (strobes.issue && !writeQ) begin
      readData <= steered;
    end
  end

  AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issue |-> (busAddr[0] == 1'b0)); // R5

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.issue && byteQ) |-> $onehot(busBe)); // R9

  AST_WRITE_KEEPS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.issue && writeQ) |=> $stable(readData)); // R11

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !strobes.issue) |=> ($stable(addrQ) && $stable(writeQ) && $stable(wdataQ))); // R2
endmodule

// File: rtl/dbg_access_top.sv
`timescale 1ns/1ps
module dbg_access_top
  import dap_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int STEAL_LIMIT = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqByte,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              cpuBusy,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busBe,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] readData,
  output logic              pending,
  output logic              done
);
  dapStrobes_t strobes;

  dap_ctrl #(.STEAL_LIMIT(STEAL_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cpuBusy(cpuBusy),
    .strobes(strobes), .pending(pending), .done(done)
  );

  dap_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pending(pending),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqByte(reqByte),
    .reqWdata(reqWdata), .busRdata(busRdata), .busWrite(busWrite),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata),
    .readData(readData)
  );

  assign busValid = strobes.issue;

  AST_DONE_FOLLOWS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> (done && !pending)); // R10

  AST_VALID_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> pending); // R3
endmodule

// File: tb/tb_dbg_access_top.sv
`timescale 1ns/1ps
module tb_dbg_access_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqByte = 1'b0;
  logic [15:0] reqWdata = '0;
  logic        cpuBusy = 1'b0;
  logic        busValid, busWrite;
  logic [15:0] busAddr, busWdata, busRdata, readData;
  logic [1:0]  busBe;
  logic        pending, done;

  int total = 0;
  int failed = 0;

  always #2.5 clk = ~clk;

  dbg_access_top dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqByte(reqByte), .reqWdata(reqWdata),
    .cpuBusy(cpuBusy), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata),
    .busRdata(busRdata), .readData(readData), .pending(pending), .done(done)
  );

  // Simple memory: word index = byte address [8:1], upper lane = even byte
  logic [15:0] mem   [256];
  logic [15:0] model [256];
  assign busRdata = mem[busAddr[8:1]];

  always @(posedge clk) begin
    if (busValid && busWrite) begin
      if (busBe[1]) mem[busAddr[8:1]][15:8] <= busWdata[15:8];
      if (busBe[0]) mem[busAddr[8:1]][7:0]  <= busWdata[7:0];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {write, byte, addr, wdata, busyCycles}
  localparam int NV = 12;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h0010, 16'h0000, 8'd0},
    {1'b0, 1'b0, 16'h0013, 16'h0000, 8'd2},
    {1'b0, 1'b1, 16'h0020, 16'h0000, 8'd1},
    {1'b0, 1'b1, 16'h0021, 16'h0000, 8'd0},
    {1'b1, 1'b0, 16'h0040, 16'h1234, 8'd3},
    {1'b0, 1'b0, 16'h0040, 16'h0000, 8'd0},
    {1'b1, 1'b1, 16'h0041, 16'hCDAB, 8'd4},
    {1'b0, 1'b0, 16'h0040, 16'h0000, 8'd1},
    {1'b1, 1'b1, 16'h0050, 16'h77EE, 8'd0},
    {1'b0, 1'b1, 16'h0050, 16'h0000, 8'd200},
    {1'b1, 1'b0, 16'h0061, 16'hBEEF, 8'd128},
    {1'b0, 1'b0, 16'h0060, 16'h0000, 8'd0}
  };

  logic [15:0] expRead = '0;

  task automatic doAccess(input logic w, input logic b, input logic [15:0] a,
                          input logic [15:0] wd, input int busyN, input bit intrude);
    int cnt = 0;
    bit issued = 0;
    int expIssue = (busyN < 128) ? busyN : 128;
    logic [15:0] m = model[a[8:1]];
    logic [1:0] expBe = !b ? 2'b11 : (a[0] ? 2'b01 : 2'b10);
    if (!w) begin
      if (!b)       expRead = m;                 // R6
      else if (!a[0]) expRead = {m[15:8], 8'h00}; // R7
      else          expRead = {8'h00, m[7:0]};   // R8
    end else begin
      if (!b) model[a[8:1]] = wd;
      else if (!a[0]) model[a[8:1]][15:8] = wd[15:8];
      else model[a[8:1]][7:0] = wd[7:0];
    end
    @(negedge clk);
    reqValid = 1; reqWrite = w; reqByte = b; reqAddr = a; reqWdata = wd;
    cpuBusy = (busyN > 0);
    @(negedge clk);
    reqValid = 0;
    #1 chk(pending == 1'b1, "R2 pending after request", 32'(pending), 1);
    while (!issued && cnt < 300) begin
      cpuBusy = (cnt < busyN);
      if (intrude) begin
        reqValid = 1; reqAddr = 16'h0100; reqWrite = 1; reqByte = 0; reqWdata = 16'hDEAD;
      end
      #1;
      if (busValid) begin
        issued = 1;
        chk(cnt == expIssue, (busyN > 128) ? "R4 forced access cycle" : "R3 access cycle", 32'(cnt), 32'(expIssue));
        chk(busAddr == {a[15:1], 1'b0}, "R5 bus address", 32'(busAddr), 32'({a[15:1], 1'b0}));
        chk(busBe == expBe && busWrite == w, "R9 lane enables", 32'({busWrite, busBe}), 32'({w, expBe}));
        if (w) chk(busWdata == wd, "R9 write data", 32'(busWdata), 32'(wd));
      end else begin
        @(negedge clk);
        cnt++;
      end
    end
    if (!issued) chk(0, "R4 no access", 32'(cnt), 32'(expIssue));
    @(negedge clk);
    reqValid = 0; reqWrite = 0; cpuBusy = 0;
    #1 chk(done && !pending, "R10 done pulse", 32'({done, pending}), 32'h2);
    chk(readData == expRead, w ? "R11 read reg kept on write" : "R6 R7 R8 read data",
        32'(readData), 32'(expRead));
    @(negedge clk);
    #1 chk(!done, "R10 done single cycle", 32'(done), 0);
  endtask

  initial begin
    #1000000;
    total++; failed++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 16'(i * 16'h0101) ^ 16'hA55A;
      model[i] = 16'(i * 16'h0101) ^ 16'hA55A;
    end
    repeat (3) @(negedge clk);
    #1 chk(!pending && !done && !busValid && readData == 0, "R1 reset state",
           32'({pending, done, busValid, readData}), 0);
    rstN = 1;
    @(negedge clk);
    #1 chk(!pending && !busValid, "R1 idle after reset", 32'({pending, busValid}), 0);

    for (int v = 0; v < NV; v++)
      doAccess(VEC[v][41], VEC[v][40], VEC[v][39:24], VEC[v][23:8], int'(VEC[v][7:0]), 0);

    // R2: requests during pending are ignored
    doAccess(1'b0, 1'b1, 16'h0031, 16'h0000, 6, 1);
    doAccess(1'b0, 1'b0, 16'h0100, 16'h0000, 0, 0);  // untouched by intruder
    // R4: exact bound with busy held forever
    doAccess(1'b0, 1'b0, 16'h0002, 16'h0000, 255, 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule